// File: doc/BRIEF.md
# Framed Serial Capture Receiver

The block takes in a serial bit stream that is clocked by an external sequence clock and qualified by a frame-enable input. While capture is armed, every rising sequence-clock edge with frame-enable high takes one data bit, most significant bit first. Each group of `DATA_SIZE` bits becomes one 32-bit output word. The top nibble of the word is a fixed identifier. The lowest `DATA_SIZE` bits hold the captured sample. The frame counter fills the bits in between. The sample width is a compile-time parameter, and the frame counter gets whatever width the sample leaves free.

Finished words cross from the sequence-clock domain into the bus-clock domain through an 8-entry dual-clock FIFO with Gray-coded pointers. On the bus side they leave through a valid/ready handshake. A word that arrives while the FIFO is full is dropped, and a saturating counter records it.

A small register slave in the bus-clock domain offers these functions: soft reset (write to address 0), a version read (address 0), capture arm (address 2, bit 0), the dropped-word count (address 3) and a read-back of `DATA_SIZE` (address 4). The capture controller is a two-state machine:
- `CAP_IDLE` means outside a frame. It takes the transition `start` to `CAP_SHIFT` when armed and frame-enable is high.
- `CAP_SHIFT` means inside a frame. It takes the transition `close` back to `CAP_IDLE` when frame-enable goes low or capture is disarmed.
- A soft reset forces `CAP_IDLE` from either state.

Top module: `serial_capture_rx`

## Requirements
- R1: Each output word is laid out as follows. Bits 31:28 hold the identifier parameter (default 4'hA). Bits 27:DATA_SIZE hold the frame counter. Bits DATA_SIZE-1:0 hold the sample. When DATA_SIZE is 28, the counter field is absent.
- R2: Bits are taken MSB first. A word is produced once DATA_SIZE bits of a frame have been taken. Further bits in the same frame start a new word that carries the same frame counter value.
- R3: A bit is taken only on a rising sequence-clock edge where frame-enable is high and capture is armed. A frame sent while disarmed produces no word and does not advance the frame counter.
- R4: The frame counter advances by one at each frame end, which is `CAP_SHIFT` with frame-enable seen low. It wraps modulo 2^(28-DATA_SIZE). Bits of an incomplete word at the frame end are discarded.
- R5: The FIFO holds 8 words in arrival order. While `out_ready` stays low, the first 8 words are kept and later words are dropped.
- R6: The dropped-word count is read at address 3. It rises by one per dropped word and saturates at 255.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R8: Reading address 0 returns 8'd1. Writing address 0 clears the frame counter, the partial shift state and the dropped-word count on the following sequence-clock edges.
- R9: Address 2, bit 0, is the read/write capture arm, with reset value 0.
- R10: Address 4 returns DATA_SIZE. Addresses 1, 5, 6 and 7 return 0.
- R11: `bus_rdata` is registered. It shows the selected value on the bus-clock edge that samples `bus_rd` high and holds it until the next read.
- R12: After reset, `out_valid` is low and the dropped-word count reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| seq_clk | input | 1 | Sequence clock for serial capture |
| frame_en | input | 1 | Frame qualifier, sequence-clock domain |
| sdi | input | 1 | Serial data, sequence-clock domain |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rd | input | 1 | Register read strobe |
| bus_rdata | output | 8 | Registered read data |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 32 | Packed output word |

## Verification
The hardest state to reach from the ports is a dropped-word count at its ceiling while the FIFO still holds its first eight words. The stimulus reaches it by holding `out_ready` low and pushing 270 complete frames through the serial port, then reading address 3 once the count has been synchronized. The words drained afterwards must carry the first eight frame-counter values in order. This shows that the dropped words never overwrote stored ones. A soft reset must then bring both the count and the frame counter back to zero.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [0:0] {
        CAP_IDLE  = 1'b0,
        CAP_SHIFT = 1'b1
    } cap_state_e;

    localparam int WORD_W    = 32;
    localparam int TAG_W     = 4;
    localparam int PAYLOAD_W = WORD_W - TAG_W;
    localparam int REG_W     = 8;

    localparam int REG_CTRL  = 0;
    localparam int REG_ARM   = 2;
    localparam int REG_LOST  = 3;
    localparam int REG_WIDTH = 4;

endpackage

// File: rtl/srx_sync2.sv
module srx_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/srx_capture.sv
module srx_capture
    import srx_pkg::*;
#(
    parameter int         DATA_SIZE = 8,
    parameter logic [3:0] IDENT     = 4'hA
) (
    input  logic              seq_clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic              soft_clr,
    input  logic              frame_en,
    input  logic              sdi,
    input  logic              fifo_full,
    output logic              push,
    output logic [WORD_W-1:0] word,
    output logic [REG_W-1:0]  lost_gray
);
    localparam int FCW   = PAYLOAD_W - DATA_SIZE;
    localparam int CNT_W = (DATA_SIZE > 1) ? $clog2(DATA_SIZE) : 1;
    localparam int SH_W  = (DATA_SIZE > 1) ? DATA_SIZE - 1 : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_SIZE - 1);

    cap_state_e state_q, state_d;
    logic take, word_done, frame_end;
    logic [CNT_W-1:0]     bit_cnt;
    logic [SH_W-1:0]      shreg;
    logic [DATA_SIZE-1:0] assembled;
    logic [REG_W-1:0]     lost_q;

    // state register
    always_ff @(posedge seq_clk or negedge rst_n) begin
        if (!rst_n)        state_q <= CAP_IDLE;
        else if (soft_clr) state_q <= CAP_IDLE;
        else               state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE:  if (armed && frame_en)    state_d = CAP_SHIFT;
            CAP_SHIFT: if (!frame_en || !armed)  state_d = CAP_IDLE;
            default:                             state_d = CAP_IDLE;
        endcase
    end

    // outputs of the controller
    always_comb begin
        take      = armed && frame_en;
        word_done = take && (bit_cnt == LAST);
        frame_end = (state_q == CAP_SHIFT) && !frame_en;
        push      = word_done && !soft_clr;
    end

    generate
        if (DATA_SIZE > 1) begin : g_multi
            assign assembled = {shreg, sdi};
        end else begin : g_single
            assign assembled = sdi;
        end
    endgenerate

    always_ff @(posedge seq_clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (soft_clr) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (take) begin
            bit_cnt <= word_done ? '0 : bit_cnt + 1'b1;
            shreg   <= assembled[SH_W-1:0];
        end else begin
            bit_cnt <= '0;
        end
    end

    generate
        if (FCW > 0) begin : g_fcnt
            logic [FCW-1:0] fcnt_q;
            always_ff @(posedge seq_clk or negedge rst_n) begin
                if (!rst_n)         fcnt_q <= '0;
                else if (soft_clr)  fcnt_q <= '0;
                else if (frame_end) fcnt_q <= fcnt_q + 1'b1;
            end
            assign word = {IDENT, fcnt_q, assembled};

            // R4
            fcnt_step_chk: assert property (@(posedge seq_clk) disable iff (!rst_n)
                (fcnt_q != $past(fcnt_q)) |-> (fcnt_q == $past(fcnt_q) + 1'b1 || fcnt_q == '0));
        end else begin : g_nofcnt
            assign word = {IDENT, assembled};
        end
    endgenerate

    always_ff @(posedge seq_clk or negedge rst_n) begin
        if (!rst_n) begin
            lost_q    <= '0;
            lost_gray <= '0;
        end else begin
            if (soft_clr)
                lost_q <= '0;
            else if (push && fifo_full && lost_q != 8'hFF)
                lost_q <= lost_q + 8'd1;
            lost_gray <= lost_q ^ (lost_q >> 1);
        end
    end

    // R6
    lost_step_chk: assert property (@(posedge seq_clk) disable iff (!rst_n)
        (lost_q != $past(lost_q)) |-> (lost_q == $past(lost_q) + 8'd1 || lost_q == 8'd0));

    // R6
    lost_sat_chk: assert property (@(posedge seq_clk) disable iff (!rst_n)
        ($past(lost_q) == 8'hFF && !$past(soft_clr)) |-> lost_q == 8'hFF);

endmodule

// File: rtl/srx_cdc_fifo.sv
module srx_cdc_fifo #(
    parameter int WIDTH = 32,
    parameter int AW    = 3
) (
    input  logic             rst_n,
    input  logic             wclk,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic             full,
    input  logic             rclk,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [WIDTH-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0] wbin_q, wgray_q, rbin_q, rgray_q;
    logic [AW:0] rgray_w, wgray_r;
    logic [AW:0] wbin_nx, rbin_nx;
    logic        pop;

    srx_sync2 #(.W(AW+1)) u_rsync (.clk(wclk), .rst_n(rst_n), .d(rgray_q), .q(rgray_w));
    srx_sync2 #(.W(AW+1)) u_wsync (.clk(rclk), .rst_n(rst_n), .d(wgray_q), .q(wgray_r));

    assign full    = (wgray_q == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
    assign wbin_nx = wbin_q + 1'b1;

    always_ff @(posedge wclk) begin
        if (wr_en && !full) mem[wbin_q[AW-1:0]] <= wdata;
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
        end else if (wr_en && !full) begin
            wbin_q  <= wbin_nx;
            wgray_q <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    assign rd_valid = (rgray_q != wgray_r);
    assign rdata    = mem[rbin_q[AW-1:0]];
    assign pop      = rd_valid && rd_ready;
    assign rbin_nx  = rbin_q + 1'b1;

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rbin_q  <= '0;
            rgray_q <= '0;
        end else if (pop) begin
            rbin_q  <= rbin_nx;
            rgray_q <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    // R5
    wgray_onebit_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray_q ^ $past(wgray_q)) <= 1);

    // R7
    hold_until_ready_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rdata)));

endmodule

// File: rtl/srx_regs.sv
module srx_regs
    import srx_pkg::*;
#(
    parameter int DATA_SIZE = 8,
    parameter int ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [REG_W-1:0]  lost_gray_s,
    output logic              arm_q,
    output logic              soft_tgl_q
);
    localparam logic [REG_W-1:0] VERSION = 8'd1;

    logic [REG_W-1:0] lost_bin, rd_mux;

    always_comb begin
        lost_bin[REG_W-1] = lost_gray_s[REG_W-1];
        for (int i = REG_W - 2; i >= 0; i--)
            lost_bin[i] = lost_bin[i+1] ^ lost_gray_s[i];
    end

    always_comb begin
        case (bus_addr)
            ADDR_W'(REG_CTRL):  rd_mux = VERSION;
            ADDR_W'(REG_ARM):   rd_mux = {7'd0, arm_q};
            ADDR_W'(REG_LOST):  rd_mux = lost_bin;
            ADDR_W'(REG_WIDTH): rd_mux = REG_W'(DATA_SIZE);
            default:            rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q      <= 1'b0;
            soft_tgl_q <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            if (bus_wr && bus_addr == ADDR_W'(REG_CTRL)) soft_tgl_q <= ~soft_tgl_q;
            if (bus_wr && bus_addr == ADDR_W'(REG_ARM))  arm_q      <= bus_wdata[0];
            if (bus_rd) bus_rdata <= rd_mux;
        end
    end

    // R8
    version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(REG_CTRL)) |=> bus_rdata == VERSION);

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(bus_rdata));

endmodule

// File: rtl/serial_capture_rx.sv
module serial_capture_rx
    import srx_pkg::*;
#(
    parameter int         DATA_SIZE = 8,
    parameter logic [3:0] IDENT     = 4'hA,
    parameter int         FIFO_AW   = 3,
    parameter int         ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_clk,
    input  logic              frame_en,
    input  logic              sdi,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_data
);
    logic arm_b, tgl_b, arm_s, tgl_s, tgl_s_d, soft_clr;
    logic push, fifo_full;
    logic [WORD_W-1:0] word;
    logic [REG_W-1:0]  lost_gray, lost_gray_b;

    srx_regs #(.DATA_SIZE(DATA_SIZE), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .lost_gray_s(lost_gray_b), .arm_q(arm_b), .soft_tgl_q(tgl_b)
    );

    srx_sync2 #(.W(2)) u_ctl_sync (
        .clk(seq_clk), .rst_n(rst_n), .d({arm_b, tgl_b}), .q({arm_s, tgl_s})
    );

    always_ff @(posedge seq_clk or negedge rst_n) begin
        if (!rst_n) tgl_s_d <= 1'b0;
        else        tgl_s_d <= tgl_s;
    end
    assign soft_clr = tgl_s ^ tgl_s_d;

    srx_capture #(.DATA_SIZE(DATA_SIZE), .IDENT(IDENT)) u_cap (
        .seq_clk(seq_clk), .rst_n(rst_n), .armed(arm_s), .soft_clr(soft_clr),
        .frame_en(frame_en), .sdi(sdi), .fifo_full(fifo_full),
        .push(push), .word(word), .lost_gray(lost_gray)
    );

    srx_sync2 #(.W(REG_W)) u_lost_sync (
        .clk(clk), .rst_n(rst_n), .d(lost_gray), .q(lost_gray_b)
    );

    srx_cdc_fifo #(.WIDTH(WORD_W), .AW(FIFO_AW)) u_fifo (
        .rst_n(rst_n), .wclk(seq_clk), .wr_en(push), .wdata(word), .full(fifo_full),
        .rclk(clk), .rd_valid(out_valid), .rd_ready(out_ready), .rdata(out_data)
    );

    // R1
    ident_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_data[31:28] == IDENT);

endmodule

// File: tb/serial_capture_rx_tb.sv
module serial_capture_rx_tb;
    localparam int         DS = 8;
    localparam logic [3:0] ID = 4'hA;
    localparam int         NV = 6;
    localparam logic [7:0] VEC [NV] = '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81, 8'h5A};

    logic clk = 0, seq_clk = 0, rst_n = 0;
    logic frame_en = 0, sdi = 0;
    logic [2:0] bus_addr = '0;
    logic bus_wr = 0, bus_rd = 0, out_ready = 0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic out_valid;
    logic [31:0] out_data;

    int n_chk = 0, n_bad = 0, fc = 0;
    bit done = 0;

    always #4 clk = ~clk;
    always #10 seq_clk = ~seq_clk;

    serial_capture_rx #(.DATA_SIZE(DS), .IDENT(ID)) u_dut (
        .clk(clk), .rst_n(rst_n), .seq_clk(seq_clk), .frame_en(frame_en), .sdi(sdi),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1;
        @(negedge clk); bus_rd = 0; d = bus_rdata;
    endtask

    task automatic send_bits(input logic [31:0] v, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            @(negedge seq_clk); frame_en = 1; sdi = v[i];
        end
        @(negedge seq_clk); frame_en = 0; sdi = 0;
        @(negedge seq_clk);
    endtask

    task automatic get_word(input string req, input logic [31:0] exp);
        int t = 0;
        while (!out_valid && t < 200) begin @(negedge clk); t++; end
        check(req, out_data, exp);
        out_ready = 1;
        @(negedge clk); out_ready = 0;
    endtask

    function automatic logic [31:0] mk(input int f, input logic [7:0] d);
        return {ID, 20'(f), d};
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        logic [7:0] r;
        logic [31:0] held;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        // R12 reset state
        check("R12 valid", {31'd0, out_valid}, 32'd0);
        bus_read(3'd3, r); check("R12 lost", {24'd0, r}, 32'd0);
        bus_read(3'd0, r); check("R8 version", {24'd0, r}, 32'd1);
        bus_read(3'd2, r); check("R9 arm reset", {24'd0, r}, 32'd0);
        bus_read(3'd4, r); check("R10 width", {24'd0, r}, DS);
        bus_read(3'd1, r); check("R10 unused addr", {24'd0, r}, 32'd0);
        // R11: value holds after the read strobe is gone
        repeat (3) @(negedge clk);
        check("R11 hold", {24'd0, bus_rdata}, 32'd0);

        // R3: disarmed frame yields nothing
        send_bits(32'hC3, 8);
        repeat (40) @(negedge clk);
        check("R3 no word", {31'd0, out_valid}, 32'd0);

        bus_write(3'd2, 8'h01);
        bus_read(3'd2, r); check("R9 arm set", {24'd0, r}, 32'd1);
        repeat (5) @(negedge seq_clk);

        // R1 R2 table walk; first fc 0 also confirms R3
        for (int k = 0; k < NV; k++) begin
            send_bits({24'd0, VEC[k]}, 8);
            get_word("R1", mk(fc, VEC[k]));
            fc++;
        end

        // R2 two words in one frame share the counter
        send_bits(32'hBEEF, 16);
        get_word("R2 first", mk(fc, 8'hBE));
        get_word("R2 second", mk(fc, 8'hEF));
        fc++;

        // R4 partial frame: dropped bits, counter still advances
        send_bits(32'h15, 5);
        repeat (40) @(negedge clk);
        check("R4 no partial word", {31'd0, out_valid}, 32'd0);
        fc++;
        send_bits(32'h42, 8);
        get_word("R4 after partial", mk(fc, 8'h42));
        fc++;

        // R5 R6 overflow with ready held low
        for (int k = 0; k < 10; k++) send_bits(k, 8);
        repeat (20) @(negedge clk);
        bus_read(3'd3, r); check("R6 two dropped", {24'd0, r}, 32'd2);
        held = out_data;
        repeat (5) @(negedge clk);
        check("R7 valid held", {31'd0, out_valid}, 32'd1);
        check("R7 data held", out_data, held);
        for (int k = 0; k < 260; k++) send_bits(32'h33, 8);
        repeat (20) @(negedge clk);
        bus_read(3'd3, r); check("R6 saturate", {24'd0, r}, 32'd255);
        for (int k = 0; k < 8; k++) get_word("R5 order", mk(fc + k, 8'(k)));
        repeat (40) @(negedge clk);
        check("R5 only eight kept", {31'd0, out_valid}, 32'd0);

        // R8 soft reset
        bus_write(3'd0, 8'h00);
        repeat (6) @(negedge seq_clk);
        repeat (10) @(negedge clk);
        bus_read(3'd3, r); check("R8 lost cleared", {24'd0, r}, 32'd0);
        bus_read(3'd2, r); check("R8 arm kept", {24'd0, r}, 32'd1);
        send_bits(32'h77, 8);
        get_word("R8 counter cleared", mk(0, 8'h77));

        done = 1;
        finish_run();
    end
endmodule